// File: doc/BRIEF.md
# Three-Operand Integer Execute Unit

This block executes a small 32-bit integer instruction subset, one instruction word per handshake. It decodes two fixed instruction layouts. The register layout names two source registers and a destination. The immediate layout names one source register, a destination and a signed 16-bit constant. Register add, register subtract and add-immediate are supported. The 32-entry by 32-bit register file is held inside the block. Entry 0 always reads as zero and ignores writes. A register is read combinationally when its instruction is accepted. It is written on the same rising edge, so the next accepted instruction already sees the new value.

Instruction words enter on a valid/ready stream. Each accepted word yields one result beat on an output valid/ready stream. The beat carries a write-enable, the destination index, the result value and an illegal-instruction flag. The result stage holds one beat. The input is ready whenever that stage is empty or is being drained in the same cycle. While the output is valid and not taken, the beat stays unchanged and no further word is accepted. There is no memory access, no branching and no overflow trap. A decrement is written as an add-immediate with a negative constant.

Top module: `exu_core`

## Requirements
- R1: A synchronous reset clears out_valid and every register. After reset, in_ready is 1 and any register reads as 0.
- R2: Opcode bits [31:26] = 0 with funct bits [5:0] = 32 (add) writes rs[25:21] + rt[20:16] into rd[15:11].
- R3: Opcode 0 with funct = 34 (subtract) writes rs − rt into rd.
- R4: Opcode 8 (add-immediate) writes rs + sign-extended imm[15:0] into rt. The constant ranges from −32768 to +32767.
- R5: Register 0 reads as zero. A legal instruction with destination 0 reports out_wen = 0 and leaves all registers unchanged, but still reports its result and dest 0.
- R6: Any opcode other than 0 or 8, or opcode 0 with a funct other than 32 or 34, is illegal. It reports out_illegal = 1, out_wen = 0, out_dest = 0 and out_result = 0, and writes nothing.
- R7: Arithmetic wraps modulo 2^32 without any trap.
- R8: in_ready = 1 exactly when out_valid is 0 or out_ready is 1. A beat held with out_ready = 0 keeps all output fields stable. A word is taken only on in_valid && in_ready, and one that is not taken changes nothing.
- R9: A write is visible to the very next accepted instruction, with no stall.
- R10: A register-layout word with nonzero shamt bits [10:6] is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Block can take the offered word |
| in_instr | input | 32 | Instruction word |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_wen | output | 1 | The instruction wrote a register |
| out_dest | output | 5 | Destination register index |
| out_result | output | 32 | Computed value |
| out_illegal | output | 1 | Instruction was not recognised |

## Verification
The bound checker watches the stream rules on every cycle. A stalled beat must stay stable, a stall must drop input ready, and an accepted word must produce a beat. An illegal or register-0 beat must never raise write-enable, and the output must be empty right after reset. Arithmetic values, sign extension, wrap-around, protection of register 0, absence of side effects from rejected or illegal words, and back-to-back dependencies depend on register contents. Only the bench's reference model can show these, as it tracks the file across directed sequences and a long phase of random traffic and back-pressure.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int XLEN    = 32;
  localparam int NREG    = 32;
  localparam int RIDX_W  = $clog2(NREG);
  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int IMM_W   = 16;

  localparam logic [OPC_W-1:0] OPC_REG  = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDI = 6'd8;
  localparam logic [FN_W-1:0]  FN_ADD   = 6'd32;
  localparam logic [FN_W-1:0]  FN_SUB   = 6'd34;

  typedef enum logic [0:0] {
    ALU_ADD = 1'b0,
    ALU_SUB = 1'b1
  } alu_op_e;

  typedef struct packed {
    logic              legal;
    alu_op_e           op;
    logic              use_imm;
    logic [RIDX_W-1:0] src_a;
    logic [RIDX_W-1:0] src_b;
    logic [RIDX_W-1:0] dest;
    logic [XLEN-1:0]   imm;
  } dec_t;
endpackage

// File: rtl/exu_decoder.sv
module exu_decoder
  import exu_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  logic [OPC_W-1:0]  opc;
  logic [RIDX_W-1:0] f_rs, f_rt, f_rd;
  logic [4:0]        f_sh;
  logic [FN_W-1:0]   f_fn;
  logic [IMM_W-1:0]  f_imm;

  assign opc   = instr[31:26];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_sh  = instr[10:6];
  assign f_fn  = instr[5:0];
  assign f_imm = instr[15:0];

  always_comb begin
    dec         = '0;
    dec.src_a   = f_rs;
    dec.src_b   = f_rt;
    dec.imm     = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};
    dec.op      = ALU_ADD;
    unique case (opc)
      OPC_REG: begin
        dec.dest    = f_rd;
        dec.use_imm = 1'b0;
        if (f_sh == '0) begin
          if (f_fn == FN_ADD) begin
            dec.legal = 1'b1;
            dec.op    = ALU_ADD;
          end else if (f_fn == FN_SUB) begin
            dec.legal = 1'b1;
            dec.op    = ALU_SUB;
          end
        end
      end
      OPC_ADDI: begin
        dec.legal   = 1'b1;
        dec.use_imm = 1'b1;
        dec.dest    = f_rt;
        dec.op      = ALU_ADD;
      end
      default: dec.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/exu_regfile.sv
module exu_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   ra_addr,
  output logic [XLEN-1:0] ra_data,
  input  logic [AW-1:0]   rb_addr,
  output logic [XLEN-1:0] rb_data,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [XLEN-1:0] wr_data
);
  logic [XLEN-1:0] cells [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_cell
    if (i == 0) begin : g_zero
      assign cells[i] = '0;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)
          cells[i] <= '0;
        else if (wr_en && wr_addr == AW'(i))
          cells[i] <= wr_data;
      end
    end
  end

  assign ra_data = cells[ra_addr];
  assign rb_data = cells[rb_addr];
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [W-1:0] b_eff;
  logic         cin;

  always_comb begin
    b_eff = (op == ALU_SUB) ? ~b : b;
    cin   = (op == ALU_SUB);
    y     = a + b_eff + W'(cin);
  end
endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_instr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_wen,
  output logic [RIDX_W-1:0] out_dest,
  output logic [XLEN-1:0]   out_result,
  output logic              out_illegal
);
  dec_t            dec;
  logic [XLEN-1:0] opa, opb_reg, opb, alu_y;
  logic            accept, do_write;

  exu_decoder u_dec (.instr(in_instr), .dec(dec));

  exu_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .ra_addr (dec.src_a),
    .ra_data (opa),
    .rb_addr (dec.src_b),
    .rb_data (opb_reg),
    .wr_en   (do_write),
    .wr_addr (dec.dest),
    .wr_data (alu_y)
  );

  assign opb = dec.use_imm ? dec.imm : opb_reg;

  exu_alu #(.W(XLEN)) u_alu (.op(dec.op), .a(opa), .b(opb), .y(alu_y));

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign do_write = accept && dec.legal && (dec.dest != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_wen     <= 1'b0;
      out_dest    <= '0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_wen     <= do_write;
      out_illegal <= !dec.legal;
      out_dest    <= dec.legal ? dec.dest : '0;
      out_result  <= dec.legal ? alu_y : '0;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/exu_core_chk.sv
module exu_core_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_wen,
  input logic [4:0]  out_dest,
  input logic [31:0] out_result,
  input logic        out_illegal
);
  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  p_stall_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
      $stable(out_dest) && $stable(out_wen) && $stable(out_illegal)));

  p_stall_blocks_input_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_accept_gives_beat_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  p_illegal_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (!out_wen && out_dest == 5'd0 && out_result == 32'd0));

  p_zero_dest_no_write_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_dest == 5'd0) |-> !out_wen);
endmodule

bind exu_core exu_core_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_wen(out_wen),
  .out_dest(out_dest), .out_result(out_result), .out_illegal(out_illegal)
);

// File: tb/exu_core_bench.sv
`timescale 1ns/1ps
module exu_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_wen;
  logic [4:0]  out_dest;
  logic [31:0] out_result;
  logic        out_illegal;

  always #4 clk = ~clk;

  exu_core u_exu_core (.*);

  int          vectors = 0;
  int          miscompares = 0;
  logic [31:0] mreg [32];
  logic [38:0] exp_q [$];
  string       tag_q [$];
  bit          rand_ready = 0;

  function automatic logic [31:0] rtype(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] itype(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  // Reference: returns {wen, illegal, dest, result} and updates the model file
  function automatic logic [38:0] model_exec(logic [31:0] w);
    int unsigned op = w[31:26], rs = w[25:21], rt = w[20:16], rd = w[15:11];
    int unsigned sh = w[10:6], fn = w[5:0];
    longint va = mreg[rs], vb = mreg[rt];
    logic [31:0] res;
    int unsigned dst;
    if (op == 0 && sh == 0 && (fn == 32 || fn == 34)) begin
      res = (fn == 32) ? 32'(va + vb) : 32'(va - vb);
      dst = rd;
    end else if (op == 8) begin
      res = 32'(va + longint'($signed(w[15:0])));
      dst = rt;
    end else begin
      return {1'b0, 1'b1, 5'd0, 32'd0};
    end
    if (dst != 0) mreg[dst] = res;
    return {dst != 0, 1'b0, 5'(dst), res};
  endfunction

  task automatic step(input bit v, input logic [31:0] w, input string tag, output bit acc);
    @(negedge clk);
    in_valid  = v;
    in_instr  = w;
    out_ready = rand_ready ? 1'($urandom % 2) : 1'b1;
    #1;
    if (out_valid) begin
      vectors++;
      if (exp_q.size() == 0) begin
        miscompares++;
        $display("FAIL R8: beat with nothing pending, got %h expected none",
                 {out_wen, out_illegal, out_dest, out_result});
      end else begin
        if ({out_wen, out_illegal, out_dest, out_result} !== exp_q[0]) begin
          miscompares++;
          $display("FAIL %s: got wen/ill/dest/res %h expected %h", tag_q[0],
                   {out_wen, out_illegal, out_dest, out_result}, exp_q[0]);
        end
        if (out_ready) begin
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
    end
    vectors++;
    if (in_ready !== (!out_valid || out_ready)) begin
      miscompares++;
      $display("FAIL R8: in_ready %b expected %b", in_ready, !out_valid || out_ready);
    end
    acc = v && in_ready;
    if (acc) begin
      exp_q.push_back(model_exec(w));
      tag_q.push_back(tag);
    end
  endtask

  task automatic send(input logic [31:0] w, input string tag);
    bit acc;
    do step(1'b1, w, tag, acc); while (!acc);
  endtask

  task automatic drain();
    bit acc;
    while (exp_q.size() != 0 || out_valid) step(1'b0, 32'd0, "R8", acc);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    vectors++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      miscompares++;
      $display("FAIL R1: out_valid/in_ready %b%b expected 01", out_valid, in_ready);
    end
    rst = 1'b0;

    send(rtype(5, 6, 3, 0, 32), "R1");
    send(itype(8, 0, 17, 100), "R4");
    send(itype(8, 0, 18, -3), "R4");
    send(32'h02324020, "R2");
    send(rtype(17, 18, 9, 0, 34), "R3");
    send(itype(8, 10, 10, -1), "R7");
    send(itype(8, 0, 11, 32767), "R4");
    send(itype(8, 0, 12, -32768), "R4");
    send(rtype(10, 10, 13, 0, 32), "R7");
    send(rtype(0, 17, 19, 0, 34), "R7");
    send(itype(8, 17, 0, 5), "R5");
    send(rtype(0, 0, 14, 0, 32), "R5");
    send({6'h23, 5'd1, 5'd17, 16'h0004}, "R6");
    send(rtype(17, 18, 17, 0, 36), "R6");
    send(rtype(17, 0, 15, 0, 32), "R6");
    send(rtype(17, 18, 16, 3, 32), "R10");
    send(rtype(16, 0, 21, 0, 32), "R10");
    send(itype(8, 0, 20, 7), "R9");
    send(itype(8, 20, 20, 7), "R9");
    send(rtype(20, 20, 22, 0, 34), "R9");
    drain();

    rand_ready = 1;
    for (int n = 0; n < 3000; n++) begin
      bit acc;
      int k = $urandom % 5;
      int a = $urandom % 8, b = $urandom % 8, d = $urandom % 8;
      logic [31:0] w;
      case (k)
        0: w = rtype(a, b, d, 0, 32);
        1: w = rtype(a, b, d, 0, 34);
        2: w = itype(8, a, d, int'($urandom % 65536) - 32768);
        3: w = rtype(a, b, d, ($urandom % 3 == 0) ? 1 : 0, ($urandom % 2) ? 33 : 32);
        default: w = {6'($urandom % 64), 26'($urandom)};
      endcase
      step(($urandom % 4) != 0, w, "R8", acc);
    end
    rand_ready = 0;
    drain();
    for (int r = 1; r < 8; r++) send(rtype(r, 0, r, 0, 32), "R8");
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R8: watchdog expired, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule